// File: doc/BRIEF.md
# Control Channel Reset Sequencer

This block sits on the controller side of a slow serial control channel that is shared by a set of memory devices. When `start_i` is pulsed, it drives a complete reset sequence onto the channel and needs no other input while it runs. If `fast_en_i` is set, the sequence begins with a set-fast-clock command. It then sends the set-reset command and the clear-reset command as two transactions with nothing between them. Each command is one framed 16-bit request. The block produces the serial clock, the framing line and the data line from the fast system clock.

The block keeps every gap that the protocol requires. The gap between set-reset and clear-reset is timed by two counters at once: one counts serial-clock periods and the other counts fast-clock cycles. The sequencer moves on only when both minimums are met. The block also holds a gap after set-fast-clock and a gap after clear-reset. `busy_o` stays high until the gap after clear-reset ends, and `done_o` then pulses for one cycle. The device address and the broadcast flag are captured when the start is accepted.

Top module: `ctl_reset_seq`

## Requirements
- R1: While reset is asserted, and after release until a start is accepted, `busy_o`, `done_o`, `frame_o` and `sdata_o` are all low.
- R2: Each command takes 24 serial periods. `frame_o` is high for the first 4 periods and low for the remaining 20. `sdata_o` is low during the first 8 periods and then carries 16 request bits, most significant bit first.
- R3: The request word holds zero in bits 15..11, device bit 5 in bit 10, the opcode in bits 9..6, the broadcast flag in bit 5 and device bits 4..0 in bits 4..0. The opcodes are set-reset 4'b0010, set-fast-clock 4'b0100 and clear-reset 4'b1011.
- R4: With `fast_en_i`=1 the commands are set-fast-clock, set-reset, clear-reset. With `fast_en_i`=0 they are set-reset, clear-reset. Set-reset is never sent without clear-reset as the very next command.
- R5: The gap from the end of the last set-reset bit to the first framing period of clear-reset is exactly SCK_DIV*max(LONG_SCK, ceil(LONG_FAST/SCK_DIV)) fast cycles.
- R6: The gap after set-fast-clock, up to the next command, is exactly SHORT_SCK serial periods.
- R7: `done_o` goes high for one cycle exactly SHORT_SCK serial periods after the last clear-reset bit ends. `busy_o` falls on the same edge.
- R8: `busy_o` rises on the cycle after `start_i` is sampled while idle. A `start_i` that arrives while busy has no effect on the command stream or on the done pulse.
- R9: The device address and the broadcast flag are captured when the start is accepted. Changes to them while busy do not affect the packets being sent.
- R10: `sck_o` has a period of SCK_DIV fast cycles: it is low in the first half of each period and high in the second. `frame_o` and `sdata_o` change only at period boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a reset sequence (accepted only when idle) |
| fast_en_i | input | 1 | Send set-fast-clock before the reset pair |
| dev_i | input | 6 | Target device address |
| bcast_i | input | 1 | Address all devices |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |
| sck_o | output | 1 | Serial clock |
| frame_o | output | 1 | Framing line |
| sdata_o | output | 1 | Serial request data |

## Verification
The bench builds three instances with different settings, chosen so that each side of the long gap decides its length.
- The first uses the defaults (SCK_DIV=4, LONG_FAST=2816). The fast-clock minimum decides the gap, and it is an exact multiple of the period.
- The second uses SCK_DIV=6 and LONG_FAST=100. The fast-clock minimum still decides, but it has to round up to whole serial periods.
- The third uses SCK_DIV=5 and LONG_FAST=40. Here the 16-period serial minimum decides, and the odd divider gives an uneven split of the serial clock into its low and high halves.

// File: rtl/ctl_reset_pkg.sv
package ctl_reset_pkg;
  localparam int PKT_W    = 16;
  localparam int FRAME_HI = 4;
  localparam int FRAME_LO = 4;
  localparam int SLOTS    = FRAME_HI + FRAME_LO + PKT_W;
  localparam int DATA0    = FRAME_HI + FRAME_LO;

  typedef enum logic [3:0] {
    OP_SETR = 4'b0010,
    OP_SETF = 4'b0100,
    OP_CLRR = 4'b1011
  } op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_ALIGN, ST_SEND, ST_GAP} st_e;

  typedef logic [5:0] dev_t;

  function automatic logic [PKT_W-1:0] build_pkt(op_e op, dev_t dev, logic bc);
    build_pkt = {5'b00000, dev[5], op, bc, dev[4:0]};
  endfunction
endpackage

// File: rtl/ctl_sck_gen.sv
module ctl_sck_gen #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o,
  output logic sck_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF = CW'(DIV / 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
  assign sck_o  = (cnt_q >= HALF);
endmodule

// File: rtl/ctl_gap_timer.sv
module ctl_gap_timer #(
  parameter int SCK_MAX  = 16,
  parameter int FAST_MAX = 2816,
  localparam int SW = $clog2(SCK_MAX + 2),
  localparam int FW = $clog2(FAST_MAX + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          tick_i,
  input  logic [SW-1:0] need_sck_i,
  input  logic [FW-1:0] need_fast_i,
  output logic          met_o
);
  logic [SW-1:0] sck_q,  sck_nx;
  logic [FW-1:0] fast_q, fast_nx;

  assign sck_nx  = sck_q + 1'b1;
  assign fast_nx = fast_q + 1'b1;

  // both minimums counted in parallel; exit only on a period boundary
  assign met_o = tick_i && (sck_nx >= need_sck_i) && (fast_nx >= need_fast_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= '0;
      fast_q <= '0;
    end else if (clear_i) begin
      sck_q  <= '0;
      fast_q <= '0;
    end else begin
      if (tick_i && sck_q < SW'(SCK_MAX)) sck_q <= sck_nx;
      if (fast_q < FW'(FAST_MAX))         fast_q <= fast_nx;
    end
  end
endmodule

// File: rtl/ctl_pkt_ser.sv
module ctl_pkt_ser
  import ctl_reset_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [PKT_W-1:0] pkt_i,
  output logic             frame_o,
  output logic             sdata_o,
  output logic             end_o
);
  localparam int SLW = $clog2(SLOTS);
  localparam logic [SLW-1:0] SLOT_LAST = SLW'(SLOTS - 1);
  localparam logic [SLW-1:0] SLOT_D0   = SLW'(DATA0);
  localparam logic [SLW-1:0] SLOT_FH   = SLW'(FRAME_HI);

  logic             active_q;
  logic [SLW-1:0]   slot_q;
  logic [PKT_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      sh_q     <= '0;
    end else if (tick_i) begin
      if (load_i) begin
        active_q <= 1'b1;
        slot_q   <= '0;
        sh_q     <= pkt_i;
      end else if (active_q) begin
        if (slot_q == SLOT_LAST) active_q <= 1'b0;
        else                     slot_q   <= slot_q + 1'b1;
        if (slot_q >= SLOT_D0)   sh_q     <= {sh_q[PKT_W-2:0], 1'b0};
      end
    end
  end

  assign frame_o = active_q && (slot_q < SLOT_FH);
  assign sdata_o = active_q && (slot_q >= SLOT_D0) && sh_q[PKT_W-1];
  assign end_o   = tick_i && active_q && (slot_q == SLOT_LAST);

  assert_rsv_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && slot_q >= SLOT_D0 && slot_q < SLOT_D0 + SLW'(5)) |-> !sdata_o);

  assert_edge_align_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> ($stable(frame_o) && $stable(sdata_o)));
endmodule

// File: rtl/ctl_reset_seq.sv
module ctl_reset_seq
  import ctl_reset_pkg::*;
#(
  parameter int SCK_DIV   = 4,
  parameter int LONG_SCK  = 16,
  parameter int LONG_FAST = 2816,
  parameter int SHORT_SCK = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       fast_en_i,
  input  logic [5:0] dev_i,
  input  logic       bcast_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       sck_o,
  output logic       frame_o,
  output logic       sdata_o
);
  localparam int SCK_MAX = (LONG_SCK > SHORT_SCK) ? LONG_SCK : SHORT_SCK;
  localparam int SW = $clog2(SCK_MAX + 2);
  localparam int FW = $clog2(LONG_FAST + 2);

  st_e  state_q;
  op_e  op_q, op_nx, load_op;
  dev_t dev_q;
  logic bc_q, done_q;
  logic tick, pkt_end, met, load;
  logic [SW-1:0] need_sck;
  logic [FW-1:0] need_fast;
  logic [PKT_W-1:0] pkt;

  ctl_sck_gen #(.DIV(SCK_DIV)) u_sck (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick), .sck_o(sck_o)
  );

  always_comb begin
    case (op_q)
      OP_SETF: op_nx = OP_SETR;
      OP_SETR: op_nx = OP_CLRR;
      default: op_nx = OP_CLRR;
    endcase
  end

  assign load    = (state_q == ST_ALIGN && tick) ||
                   (state_q == ST_GAP && met && op_q != OP_CLRR);
  assign load_op = (state_q == ST_ALIGN) ? op_q : op_nx;
  assign pkt     = build_pkt(load_op, dev_q, bc_q);

  assign need_sck  = (op_q == OP_SETR) ? SW'(LONG_SCK)  : SW'(SHORT_SCK);
  assign need_fast = (op_q == OP_SETR) ? FW'(LONG_FAST) : '0;

  ctl_pkt_ser u_ser (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .load_i(load), .pkt_i(pkt),
    .frame_o(frame_o), .sdata_o(sdata_o), .end_o(pkt_end)
  );

  ctl_gap_timer #(.SCK_MAX(SCK_MAX), .FAST_MAX(LONG_FAST)) u_gap (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(pkt_end), .tick_i(tick),
    .need_sck_i(need_sck), .need_fast_i(need_fast), .met_o(met)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_SETR;
      dev_q   <= '0;
      bc_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_ALIGN;
          op_q    <= fast_en_i ? OP_SETF : OP_SETR;
          dev_q   <= dev_i;
          bc_q    <= bcast_i;
        end
        ST_ALIGN: if (tick) state_q <= ST_SEND;
        ST_SEND:  if (pkt_end) state_q <= ST_GAP;
        ST_GAP: if (met) begin
          if (op_q == OP_CLRR) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_SEND;
            op_q    <= op_nx;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  // independent gap watch for the reset pair
  logic [31:0] chk_fast_q, chk_sck_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_fast_q <= '0;
      chk_sck_q  <= '0;
    end else if (pkt_end) begin
      chk_fast_q <= '0;
      chk_sck_q  <= '0;
    end else begin
      if (chk_fast_q < 32'h00ff_ffff) chk_fast_q <= chk_fast_q + 1;
      if (tick && chk_sck_q < 32'h00ff_ffff) chk_sck_q <= chk_sck_q + 1;
    end
  end

  assert_long_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && state_q == ST_GAP && op_q == OP_SETR) |->
      (chk_fast_q + 1 >= 32'(LONG_FAST) && chk_sck_q + 1 >= 32'(LONG_SCK)));

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_hold_cfg_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(dev_q) && $stable(bc_q)));
endmodule

// File: tb/ctl_reset_seq_mon.sv
module ctl_reset_seq_mon #(
  parameter int    DIV       = 4,
  parameter int    LONG_SCK  = 16,
  parameter int    LONG_FAST = 2816,
  parameter int    SHORT_SCK = 4,
  parameter string NAME      = "a"
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       fast_en,
  input  logic [5:0] dev,
  input  logic       bcast,
  input  logic       busy,
  input  logic       done,
  input  logic       sck,
  input  logic       frame,
  input  logic       sdata,
  output int         checks_o,
  output int         fails_o
);
  localparam logic [3:0] SETR = 4'b0010, SETF = 4'b0100, CLRR = 4'b1011;

  int cyc, last_rise, sl, pkt_end_t, idx, n_exp, exp_done;
  logic sck_p, frame_p, sdata_p, done_p, in_run, have_prev, busy_pend;
  logic [15:0] shreg;
  logic [3:0] ops [3];
  logic [3:0] prev_op;
  logic [5:0] xdev;
  logic xbc;

  function automatic int long_gap();
    int p;
    p = (LONG_FAST + DIV - 1) / DIV;
    return DIV * ((p > LONG_SCK) ? p : LONG_SCK);
  endfunction

  function automatic logic [15:0] exp_pkt(logic [3:0] op, logic [5:0] d, logic b);
    return {5'b00000, d[5], op, b, d[4:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks_o++;
    if (!ok) begin
      fails_o++;
      $display("FAIL %s [%s] %s: actual %0d expected %0d", req, NAME, what, act, exp);
    end
  endtask

  initial begin
    checks_o = 0;
    fails_o  = 0;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; last_rise = -1; sl = -1; idx = 0; n_exp = 0; exp_done = -1;
      sck_p = 0; frame_p = 0; sdata_p = 0; done_p = 0;
      in_run = 0; have_prev = 0; busy_pend = 0; shreg = '0; prev_op = '0;
      pkt_end_t = 0;
    end else begin
      cyc++;
      if (busy_pend) begin
        chk(busy, "R8", "busy after start", int'(busy), 1);
        busy_pend = 0;
      end
      if (start && !busy) begin
        in_run = 1; have_prev = 0; idx = 0; busy_pend = 1; exp_done = -1;
        xdev = dev; xbc = bcast;
        if (fast_en) begin
          ops[0] = SETF; ops[1] = SETR; ops[2] = CLRR; n_exp = 3;
        end else begin
          ops[0] = SETR; ops[1] = CLRR; ops[2] = CLRR; n_exp = 2;
        end
      end
      if (sck && !sck_p) begin
        if (last_rise >= 0) chk(cyc - last_rise == DIV, "R10", "sck period", cyc - last_rise, DIV);
        chk(frame == frame_p && sdata == sdata_p, "R10", "line moved at sck rise",
            int'({frame, sdata}), int'({frame_p, sdata_p}));
        last_rise = cyc;
        if (sl < 0 && frame) begin
          sl = 0;
          if (in_run && have_prev) begin
            if (prev_op == SETR)
              chk(cyc - pkt_end_t - DIV == long_gap(), "R5", "pair gap",
                  cyc - pkt_end_t - DIV, long_gap());
            else
              chk(cyc - pkt_end_t - DIV == SHORT_SCK * DIV, "R6", "gap after fast",
                  cyc - pkt_end_t - DIV, SHORT_SCK * DIV);
          end
        end
        if (sl >= 0) begin
          if (sl < 4) chk(frame, "R2", "frame high slot", int'(frame), 1);
          else if (!frame) ; else chk(0, "R2", "frame low slot", int'(frame), 0);
          if (sl < 8) begin
            if (sdata) chk(0, "R2", "data idle in preamble", int'(sdata), 0);
          end else shreg = {shreg[14:0], sdata};
          sl++;
          if (sl == 24) begin
            sl = -1;
            pkt_end_t = cyc;
            chk(in_run && idx < n_exp, "R4", "packet outside sequence", idx, n_exp);
            if (in_run && idx < n_exp) begin
              chk(shreg[9:6] == ops[idx], "R4", "opcode order", int'(shreg[9:6]), int'(ops[idx]));
              chk(shreg == exp_pkt(ops[idx], xdev, xbc), "R3", "packet word",
                  int'(shreg), int'(exp_pkt(ops[idx], xdev, xbc)));
              chk(busy, "R8", "busy during sequence", int'(busy), 1);
              prev_op = ops[idx];
              idx++;
              have_prev = 1;
              if (prev_op == CLRR) exp_done = cyc + 5 * DIV - DIV / 2;
            end
          end
        end
      end
      if (done) begin
        chk(in_run && idx == n_exp && cyc == exp_done, "R7", "done timing", cyc, exp_done);
        chk(!busy, "R7", "busy low with done", int'(busy), 0);
        chk(!done_p, "R7", "done one cycle", int'(done_p), 0);
        in_run = 0;
      end else if (in_run && cyc == exp_done) begin
        chk(0, "R7", "done missing", 0, 1);
        in_run = 0;
      end
      sck_p = sck; frame_p = frame; sdata_p = sdata; done_p = done;
    end
  end
endmodule

// File: tb/ctl_reset_seq_test.sv
`timescale 1ns/1ps
module ctl_reset_seq_test;
  logic clk = 0, rst_n = 0;
  logic start = 0, fast_en = 0, bcast = 0;
  logic [5:0] dev = '0;
  logic busy_a, done_a, sck_a, frame_a, sdata_a;
  logic busy_b, done_b, sck_b, frame_b, sdata_b;
  logic busy_c, done_c, sck_c, frame_c, sdata_c;
  int ck_a, fl_a, ck_b, fl_b, ck_c, fl_c;
  int bchecks = 0, bfails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ctl_reset_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .fast_en_i(fast_en), .dev_i(dev),
    .bcast_i(bcast), .busy_o(busy_a), .done_o(done_a), .sck_o(sck_a),
    .frame_o(frame_a), .sdata_o(sdata_a));
  ctl_reset_seq #(.SCK_DIV(6), .LONG_FAST(100)) uut_b (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .fast_en_i(fast_en), .dev_i(dev),
    .bcast_i(bcast), .busy_o(busy_b), .done_o(done_b), .sck_o(sck_b),
    .frame_o(frame_b), .sdata_o(sdata_b));
  ctl_reset_seq #(.SCK_DIV(5), .LONG_FAST(40)) uut_c (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .fast_en_i(fast_en), .dev_i(dev),
    .bcast_i(bcast), .busy_o(busy_c), .done_o(done_c), .sck_o(sck_c),
    .frame_o(frame_c), .sdata_o(sdata_c));

  ctl_reset_seq_mon #(.DIV(4), .LONG_FAST(2816), .NAME("div4")) mon_a (
    .clk(clk), .rst_n(rst_n), .start(start), .fast_en(fast_en), .dev(dev), .bcast(bcast),
    .busy(busy_a), .done(done_a), .sck(sck_a), .frame(frame_a), .sdata(sdata_a),
    .checks_o(ck_a), .fails_o(fl_a));
  ctl_reset_seq_mon #(.DIV(6), .LONG_FAST(100), .NAME("div6")) mon_b (
    .clk(clk), .rst_n(rst_n), .start(start), .fast_en(fast_en), .dev(dev), .bcast(bcast),
    .busy(busy_b), .done(done_b), .sck(sck_b), .frame(frame_b), .sdata(sdata_b),
    .checks_o(ck_b), .fails_o(fl_b));
  ctl_reset_seq_mon #(.DIV(5), .LONG_FAST(40), .NAME("div5")) mon_c (
    .clk(clk), .rst_n(rst_n), .start(start), .fast_en(fast_en), .dev(dev), .bcast(bcast),
    .busy(busy_c), .done(done_c), .sck(sck_c), .frame(frame_c), .sdata(sdata_c),
    .checks_o(ck_c), .fails_o(fl_c));

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               bchecks + ck_a + ck_b + ck_c, bfails + fl_a + fl_b + fl_c);
      $finish;
    end
  endtask

  task automatic check_quiet(input string when);
    logic [11:0] v;
    v = {busy_a, done_a, frame_a, sdata_a, busy_b, done_b, frame_b, sdata_b,
         busy_c, done_c, frame_c, sdata_c};
    bchecks++;
    if (v != '0) begin
      bfails++;
      $display("FAIL R1 %s: actual %h expected 000", when, v);
    end
  endtask

  task automatic run_seq(input logic fe, input logic [5:0] d, input logic bc, input bit noise);
    @(posedge clk); #1;
    start = 1; fast_en = fe; dev = d; bcast = bc;
    @(posedge clk); #1;
    start = 0;
    if (noise) begin
      // R8 and R9: late start and changed address while busy
      repeat (50) @(posedge clk);
      #1;
      dev = ~d; bcast = ~bc; fast_en = ~fe; start = 1;
      @(posedge clk); #1;
      start = 0;
    end
    while (busy_a || busy_b || busy_c) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bfails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int seed_val;
    seed_val = $urandom(32'd4711);
    repeat (4) @(posedge clk);
    @(negedge clk) check_quiet("in reset");
    @(posedge clk); #1 rst_n = 1;
    repeat (10) @(negedge clk);
    check_quiet("after release");
    run_seq(1'b1, 6'h2A, 1'b0, 1'b0);
    run_seq(1'b0, 6'h3F, 1'b1, 1'b0);
    run_seq(1'b1, 6'h15, 1'b0, 1'b1);
    run_seq(1'b0, 6'h00, 1'b1, 1'b1);
    for (int i = 0; i < 8; i++) begin
      int r;
      r = int'($urandom());
      run_seq(r[0], r[6:1], r[7], r[8]);
    end
    @(negedge clk) check_quiet("idle after runs");
    report();
  end
endmodule